// File: doc/BRIEF.md
# Decision-Tree Peripheral Channel Resolver

This block turns a 12-bit peripheral identifier into an 8-bit channel index. The identifier is built from a 4-bit slave number and an 8-bit peripheral number. The mapping lives in a small table of 32-bit node words that a host loads through a write port. A lookup starts at node 0. At each node the engine tests one identifier bit, chosen by the node, and follows one of two branches. A branch either names another node or gives the final channel index.

A request is a single-cycle strobe taken only while the engine is idle. The answer comes back as a one-cycle response carrying the index, a found flag and the number of nodes evaluated. Node words that have already been fetched are kept in a local copy marked valid, so later walks do not fetch them again. Any host write drops every valid mark, so a changed table can never be read from a stale copy.

Top module: `idtree_lookup`

## Requirements
- R1: The identifier under test is `{reqSlave[3:0], reqPeriph[7:0]}`. Identifier bit 8 is reqSlave[0] and bit 11 is reqSlave[3].
- R2: A node word is decoded as follows. Bits 21:18 hold the identifier bit to test. Bit 17 is the zero-branch continue flag and bits 16:9 the zero-branch result. Bit 8 is the one-branch continue flag and bits 7:0 the one-branch result.
- R3: Every walk begins at node 0. It uses the one-branch pair when the tested identifier bit is 1 and the zero-branch pair when it is 0.
- R4: When the chosen flag is 1, the result is the next node to visit. When the flag is 0, the walk ends with rspFound=1 and rspIndex equal to the result.
- R5: When MAX_STEPS (16) nodes have been evaluated without reaching a terminal branch, the response has rspFound=0, rspIndex=0 and rspSteps=16.
- R6: A continue result at or above NUM_NODES ends the walk with rspFound=0 and rspIndex=0. rspSteps then equals the number of nodes evaluated.
- R7: A node evaluated from its valid local copy costs one cycle. A node without a valid copy costs one extra fetch cycle. The response therefore appears steps+misses clock edges after the accepting edge.
- R8: A host write (wrEn, byte address wrAddr, with word index wrAddr[ADDR_W-1:2]) updates that node word and invalidates every local copy. Later walks use the new contents and pay the fetch cycles again.
- R9: busy rises on the edge that accepts a request and falls on the edge that produces the response. A request presented while busy is ignored and produces no response.
- R10: rspValid is high for exactly one cycle per accepted request. rspSteps reports the number of nodes evaluated, from 1 to MAX_STEPS.
- R11: After reset, busy and rspValid are 0 and no node has a valid local copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqSlave | input | 4 | Slave number, upper identifier bits |
| reqPeriph | input | 8 | Peripheral number, lower identifier bits |
| busy | output | 1 | Walk in progress |
| rspValid | output | 1 | One-cycle response strobe |
| rspIndex | output | 8 | Resolved channel index (0 if not found) |
| rspFound | output | 1 | A terminal branch was reached |
| rspSteps | output | STEP_W | Nodes evaluated in the walk |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | ADDR_W | Byte address of the node word |
| wrData | input | 32 | Node word to store |

## Verification
The bench loads a six-node tree and resolves identifiers that take different paths through it. Some differ only in a slave bit, so they show whether the upper identifier bits are wired in. Others differ only in a peripheral bit, so they show that the correct branch pair is chosen. The paths end in one of three ways: at a terminal branch, at an out-of-range continue, or in a self-loop that runs into the step limit. This separates the three ways a walk can end. The same lookup is repeated cold and warm, and once more after a table rewrite. Comparing the latencies of these runs shows the fetch-once behaviour, and the rewrite shows that invalidation picks up the new node contents.

// File: rtl/idtree_pkg.sv
package idtree_pkg;
  localparam int ID_W    = 12;
  localparam int RES_W   = 8;
  localparam int ENTRY_W = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic fill;
    logic advance;
    logic finish;
    logic found;
  } idtStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic term;
    logic lastStep;
    logic nextOor;
  } idtStatus_t;
endpackage

// File: rtl/idtree_ctrl.sv
module idtree_ctrl
  import idtree_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  idtStatus_t stat,
  output idtStrobe_t str,
  output logic       busy
);
  typedef enum logic {ST_IDLE, ST_WALK} state_t;
  state_t state, stateNxt;

  always_comb begin
    str      = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          str.start = 1'b1;
          stateNxt  = ST_WALK;
        end
      end
      ST_WALK: begin
        if (!stat.hit) begin
          str.fill = 1'b1;
        end else if (stat.term) begin
          str.finish = 1'b1;
          str.found  = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (stat.lastStep || stat.nextOor) begin
          str.finish = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          str.advance = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state == ST_WALK);
endmodule

// File: rtl/idtree_dpath.sv
module idtree_dpath
  import idtree_pkg::*;
#(
  parameter int NUM_NODES = 32,
  parameter int MAX_STEPS = 16,
  localparam int IDX_W  = $clog2(NUM_NODES),
  localparam int STEP_W = $clog2(MAX_STEPS + 1),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  idtStrobe_t         str,
  input  logic [ID_W-1:0]    reqId,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output idtStatus_t         stat,
  output logic               rspValid,
  output logic [RES_W-1:0]   rspIndex,
  output logic               rspFound,
  output logic [STEP_W-1:0]  rspSteps
);
  logic [ENTRY_W-1:0] tblMem   [NUM_NODES];
  logic [ENTRY_W-1:0] cacheMem [NUM_NODES];
  logic [NUM_NODES-1:0] cacheVld;

  logic [ID_W-1:0]   curId;
  logic [RES_W-1:0]  curNode;
  logic [STEP_W-1:0] stepCnt;

  logic [IDX_W-1:0]   nodeIdx;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRY_W-1:0] ent;
  logic [3:0]         bitSel;
  logic               idBit;
  logic               contFlag;
  logic [RES_W-1:0]   res;

  assign nodeIdx = curNode[IDX_W-1:0];
  assign wrIdx   = wrAddr[ADDR_W-1:2];
  assign ent     = cacheMem[nodeIdx];

  // node word decode
  assign bitSel   = ent[21:18];
  assign idBit    = curId[bitSel];
  assign contFlag = idBit ? ent[8]   : ent[17];
  assign res      = idBit ? ent[7:0] : ent[16:9];

  assign stat.hit      = cacheVld[nodeIdx];
  assign stat.term     = !contFlag;
  assign stat.lastStep = (stepCnt == STEP_W'(MAX_STEPS - 1));
  assign stat.nextOor  = ({1'b0, res} >= 9'(NUM_NODES));

  // table and cached copies carry no reset
  always_ff @(posedge clk) begin
    if (wrEn && (32'(wrIdx) < NUM_NODES)) tblMem[wrIdx] <= wrData;
    if (str.fill) cacheMem[nodeIdx] <= tblMem[nodeIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheVld <= '0;
      curId    <= '0;
      curNode  <= '0;
      stepCnt  <= '0;
      rspValid <= 1'b0;
      rspIndex <= '0;
      rspFound <= 1'b0;
      rspSteps <= '0;
    end else begin
      rspValid <= str.finish;
      if (str.start) begin
        curId   <= reqId;
        curNode <= '0;
        stepCnt <= '0;
      end
      if (str.advance) begin
        curNode <= res;
        stepCnt <= stepCnt + 1'b1;
      end
      if (str.finish) begin
        rspIndex <= str.found ? res : '0;
        rspFound <= str.found;
        rspSteps <= stepCnt + 1'b1;
      end
      // a host write outranks a fill
      if (wrEn)          cacheVld <= '0;
      else if (str.fill) cacheVld[nodeIdx] <= 1'b1;
    end
  end
endmodule

// File: rtl/idtree_lookup.sv
module idtree_lookup
  import idtree_pkg::*;
#(
  parameter int NUM_NODES = 32,
  parameter int MAX_STEPS = 16,
  localparam int IDX_W  = $clog2(NUM_NODES),
  localparam int STEP_W = $clog2(MAX_STEPS + 1),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqSlave,
  input  logic [7:0]        reqPeriph,
  output logic              busy,
  output logic              rspValid,
  output logic [7:0]        rspIndex,
  output logic              rspFound,
  output logic [STEP_W-1:0] rspSteps,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData
);
  idtStrobe_t str;
  idtStatus_t stat;

  idtree_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .stat(stat), .str(str), .busy(busy)
  );

  idtree_dpath #(.NUM_NODES(NUM_NODES), .MAX_STEPS(MAX_STEPS)) dpath_i (
    .clk(clk), .rstN(rstN), .str(str),
    .reqId({reqSlave, reqPeriph}),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stat(stat), .rspValid(rspValid), .rspIndex(rspIndex),
    .rspFound(rspFound), .rspSteps(rspSteps)
  );
endmodule

// File: rtl/idtree_lookup_chk.sv
module idtree_lookup_chk #(
  parameter int NUM_NODES = 32,
  parameter int MAX_STEPS = 16,
  localparam int STEP_W = $clog2(MAX_STEPS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              rspValid,
  input logic [7:0]        rspIndex,
  input logic              rspFound,
  input logic [STEP_W-1:0] rspSteps
);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
  a_r9_idle_at_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busy);
  a_r9_busy_ends_with_rsp: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> rspValid);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r10_step_range: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspSteps != 0 && 32'(rspSteps) <= MAX_STEPS));
  a_r6_miss_index_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFound) |-> (rspIndex == 8'h00));
endmodule

bind idtree_lookup idtree_lookup_chk #(.NUM_NODES(NUM_NODES), .MAX_STEPS(MAX_STEPS)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .rspValid(rspValid), .rspIndex(rspIndex), .rspFound(rspFound), .rspSteps(rspSteps)
);

// File: tb/idtree_lookup_tb_top.sv
module idtree_lookup_tb_top;
  localparam int NUM_NODES = 32;
  localparam int MAX_STEPS = 16;
  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam int ADDR_W = $clog2(NUM_NODES) + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [3:0] reqSlave = '0;
  logic [7:0] reqPeriph = '0;
  logic busy, rspValid, rspFound;
  logic [7:0] rspIndex;
  logic [STEP_W-1:0] rspSteps;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;

  int nTests = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  idtree_lookup #(.NUM_NODES(NUM_NODES), .MAX_STEPS(MAX_STEPS)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSlave(reqSlave),
    .reqPeriph(reqPeriph), .busy(busy), .rspValid(rspValid), .rspIndex(rspIndex),
    .rspFound(rspFound), .rspSteps(rspSteps), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData)
  );

  // {slave, periph, expIndex, expFound, expSteps}
  localparam int NVEC = 7;
  localparam logic [25:0] VEC [NVEC] = '{
    {4'h8, 8'h01, 8'hA1, 1'b1, 5'd2},   // R1 R3: bit 11 set, one-branch at node 1
    {4'h8, 8'h00, 8'hA0, 1'b1, 5'd2},   // R3: zero-branch at node 1
    {4'h0, 8'h80, 8'h20, 1'b1, 5'd2},   // R1: slave bit 0 clear
    {4'h1, 8'h80, 8'h37, 1'b1, 5'd3},   // R1 R4: slave bit 0 set, deeper terminal
    {4'h1, 8'h20, 8'h00, 1'b0, 5'd4},   // R6: continue to node 40
    {4'h1, 8'h00, 8'h00, 1'b0, 5'd16},  // R5: self loop hits step limit
    {4'h9, 8'h81, 8'hA1, 1'b1, 5'd2}    // R2: fields decoded at node 0 and 1
  };

  function automatic logic [31:0] enc(input int bi, input bit f0, input int r0,
                                       input bit f1, input int r1);
    enc = (32'(bi) << 18) | (32'(f0) << 17) | (32'(r0 & 255) << 9)
        | (32'(f1) << 8) | 32'(r1 & 255);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrEntry(input int idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(idx * 4); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [3:0] s, input logic [7:0] p,
                        output int idx, output int fnd, output int st,
                        output int lat, output int nextRsp);
    int cnt;
    @(negedge clk);
    reqValid = 1'b1; reqSlave = s; reqPeriph = p;
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 1;
    while (!rspValid && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    lat = cnt - 1;
    idx = int'(rspIndex); fnd = int'(rspFound); st = int'(rspSteps);
    @(negedge clk);
    nextRsp = int'(rspValid);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int idx, fnd, st, lat, nx, seen;
    repeat (5) @(negedge clk);
    check("R11", "busy in reset", int'(busy), 0);
    check("R11", "rspValid in reset", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "busy after reset", int'(busy), 0);
    check("R11", "rspValid after reset", int'(rspValid), 0);

    wrEntry(0, enc(11, 1'b1, 2, 1'b1, 1));
    wrEntry(1, enc(0, 1'b0, 'hA0, 1'b0, 'hA1));
    wrEntry(2, enc(8, 1'b0, 'h20, 1'b1, 3));
    wrEntry(3, enc(7, 1'b1, 4, 1'b0, 'h37));
    wrEntry(4, enc(5, 1'b1, 5, 1'b1, 40));
    wrEntry(5, enc(4, 1'b1, 5, 1'b1, 5));

    // R7 R11: cold walk pays a fetch per node, warm walk does not
    lookup(4'h1, 8'h80, idx, fnd, st, lat, nx);
    check("R7", "cold latency", lat, 6);
    check("R10", "single pulse", nx, 0);
    lookup(4'h1, 8'h80, idx, fnd, st, lat, nx);
    check("R7", "warm latency", lat, 3);
    check("R4", "warm index", idx, 'h37);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VEC[i][25:22], VEC[i][21:14], idx, fnd, st, lat, nx);
      check("R4", $sformatf("vec%0d index", i), idx, int'(VEC[i][13:6]));
      check("R5", $sformatf("vec%0d found", i), fnd, int'(VEC[i][5]));
      check("R10", $sformatf("vec%0d steps", i), st, int'(VEC[i][4:0]));
    end

    // R8: rewrite node 1, new content and fresh fetches
    wrEntry(1, enc(0, 1'b0, 'hB0, 1'b0, 'hB1));
    lookup(4'h8, 8'h01, idx, fnd, st, lat, nx);
    check("R8", "new index", idx, 'hB1);
    check("R8", "refetch latency", lat, 4);

    // R9: request while busy is ignored
    @(negedge clk);
    reqValid = 1'b1; reqSlave = 4'h1; reqPeriph = 8'h00;
    @(negedge clk);
    reqValid = 1'b1; reqSlave = 4'h8; reqPeriph = 8'h01;
    check("R9", "busy during walk", int'(busy), 1);
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 100 && !rspValid; c++) @(negedge clk);
    check("R9", "first rsp found", int'(rspFound), 0);
    check("R5", "limit steps", int'(rspSteps), 16);
    check("R9", "busy at rsp", int'(busy), 0);
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (rspValid) seen++;
    end
    check("R9", "no second rsp", seen, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule